// File: doc/BRIEF.md
# Frame Header and Palette Decoder

At the start of every frame this block works out how the pixel data in the frame buffer is to be read. In the palette modes it fetches a 256-entry table of 16-bit colours from the start of the buffer, one word at a time, and stores it. Entry 0 of that table also carries a 3-bit depth code. From the depth code the block derives the bits per pixel, the pixel-format select for the downstream converter, and the byte offset at which pixel data begins.

Before a frame is accepted, the block checks that the programmed width and height fit in the buffer at that depth. It then applies the sub-panel setting, which either moves the first displayed line or shortens the number of lines. The result is one pulse per frame: accepted (with the frame parameters updated), skipped, or sync error. The register block that owns the enable bit drops it on a sync error.

Top module: `frame_hdr_decoder`

## Requirements
- R1: After reset, no memory request is made, all result pulses are low, and every frame parameter output reads zero.
- R2: A frame starts only when `frame_start` is high while `ctl_enable` is high. A start pulse while disabled causes no memory read and no pulse.
- R3: In modes 0 and 3, the block reads 256 16-bit words from `buf_base + 2*i` for i = 0..255. It holds `mem_req` and `mem_addr` steady until `mem_ack` arrives. After the last word it gives one `palette_done` pulse, and entry i can then be read on `pal_entry` by setting `pal_idx` = i.
- R4: The depth code is bits 14:12 of entry 0. Codes 1, 2 and 3 give 2, 4 and 8 bits per pixel, and codes 4 to 7 give 16. `bpp_out` carries the number itself.
- R5: `fmt_out` is 0 for 2 bpp, 1 for 4 bpp and 2 for 8 bpp. At 16 bpp it is 3 (12-bit colour) when `tft_sel` is 0 and 4 (16-bit colour) when `tft_sel` is 1.
- R6: `data_addr` is `buf_base` plus an offset. The offset is 0x200 for depth codes 3 to 7, 0x20 for codes 1 and 2, and 0 in mode 2.
- R7: In mode 1, a start gives one `frame_skip` pulse and no memory read.
- R8: Mode 2 makes no memory read and gives no `palette_done`. It uses the depth code captured by the most recent palette load; after reset that code is 0.
- R9: Depth code 0 gives `frame_skip` and no `frame_go`.
- R10: Let need = offset + width*height*bpp/8, with width = `pix_w_m1`+1 and height = `lines_m1`+1. If need is greater than `buf_size`+2, the block pulses `sync_err` and not `frame_go`. If need equals `buf_size`+2, the frame is accepted.
- R11: With `sub_on` high, `sub_value` becomes `first_line` (and `line_count` stays the height) if `sub_first_mode` is 1. Otherwise `sub_value` becomes `line_count` and `first_line` is 0. With `sub_on` low, `first_line` is 0 and `line_count` is the height, whatever `sub_first_mode` is.
- R12: `line_stride` is width*bpp/8 bytes.
- R13: Each started frame gives exactly one of `frame_go`, `frame_skip` or `sync_err`, each one cycle long. The frame parameter outputs change only together with `frame_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Start-of-frame pulse |
| ctl_enable | input | 1 | Controller enabled |
| pal_mode | input | 2 | 0/3 palette load, 1 no fetch, 2 no palette |
| tft_sel | input | 1 | Active-matrix panel select |
| pix_w_m1 | input | DIM_W | Width minus one |
| lines_m1 | input | DIM_W | Height minus one |
| sub_on | input | 1 | Sub-panel enabled |
| sub_first_mode | input | 1 | Sub-panel value is the first line (1) or the line count (0) |
| sub_value | input | DIM_W | Sub-panel line value |
| buf_base | input | AW | Frame buffer byte address |
| buf_size | input | AW | Frame buffer size in bytes |
| mem_req | output | 1 | Word read request |
| mem_addr | output | AW | Word read byte address |
| mem_ack | input | 1 | Read data valid, request accepted |
| mem_rdata | input | PAL_DW | Read data |
| pal_idx | input | IDX_W | Palette read index |
| pal_entry | output | PAL_DW | Palette entry at `pal_idx` |
| palette_done | output | 1 | Palette load complete pulse |
| frame_go | output | 1 | Frame accepted pulse |
| frame_skip | output | 1 | Frame skipped pulse |
| sync_err | output | 1 | Buffer too small pulse |
| bpp_out | output | 5 | Bits per pixel |
| fmt_out | output | 3 | Pixel-format select |
| data_addr | output | AW | Pixel data start address |
| line_stride | output | DIM_W+2 | Bytes per line |
| first_line | output | DIM_W | First displayed line |
| line_count | output | DIM_W+1 | Displayed line count |

## Verification
The hardest case to reach is mode 2. It has no header of its own and relies on a depth code that an earlier frame left behind. The bench therefore runs it right after a palette load with a known code and checks that no read happens. The size boundary is just as narrow, since it passes or fails on a single byte. The bench picks a resolution whose need is exactly `buf_size`+2 and then lowers the size by one.

// File: rtl/fhd_pkg.sv
// Package: shared types and constants of the frame header decoder.
// Assumes: the depth code sits at bits 14:12 of palette entry 0.
package fhd_pkg;

    typedef enum logic [2:0] {
        FMT_P2  = 3'd0,
        FMT_P4  = 3'd1,
        FMT_P8  = 3'd2,
        FMT_C12 = 3'd3,
        FMT_C16 = 3'd4
    } pix_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EVAL = 2'd2
    } seq_state_e;

    localparam logic [1:0] MODE_NOFETCH = 2'd1;
    localparam logic [1:0] MODE_NOPAL   = 2'd2;
    localparam int         HDR_LSB      = 12;

endpackage

// File: rtl/fhd_pal_loader.sv
// Module: fhd_pal_loader
// Reads PAL_N words from the buffer start into local storage.
// Captures the depth code from word 0 and pulses done after the last word.
// Assumes: one request outstanding; mem_ack accepts the request and carries its data.
module fhd_pal_loader
    import fhd_pkg::*;
#(
    parameter int AW     = 32,
    parameter int PAL_DW = 16,
    parameter int PAL_N  = 256,
    localparam int IDX_W = $clog2(PAL_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     base,
    input  logic              mem_ack,
    input  logic [PAL_DW-1:0] mem_rdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic [2:0]        hdr_code,
    output logic              done,
    output logic [PAL_DW-1:0] rd_data
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAL_N - 1);

    logic              busy;
    logic [IDX_W-1:0]  idx;
    logic [AW-1:0]     base_q;
    logic [PAL_DW-1:0] pal_mem [PAL_N];

    // Word address of the current entry.
    assign mem_addr = base_q + (AW'(idx) << 1);
    assign mem_req  = busy;
    assign rd_data  = pal_mem[rd_idx];

    // Sequence the reads and pulse done after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            idx      <= '0;
            base_q   <= '0;
            hdr_code <= 3'd0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                busy   <= 1'b1;
                idx    <= '0;
                base_q <= base;
            end else if (busy && mem_ack) begin
                if (idx == '0) begin
                    hdr_code <= mem_rdata[HDR_LSB+2:HDR_LSB];
                end
                if (idx == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // Store each returned word in the palette.
    always_ff @(posedge clk) begin
        if (busy && mem_ack) begin
            pal_mem[idx] <= mem_rdata;
        end
    end

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_done_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_ack));

endmodule

// File: rtl/fhd_hdr_decode.sv
// Module: fhd_hdr_decode
// Maps the depth code to bits-per-pixel (as a log2), the format select and the data offset.
// Assumes: code 0 is unsupported; no_pal forces a zero offset.
module fhd_hdr_decode
    import fhd_pkg::*;
(
    input  logic [2:0] code,
    input  logic       tft,
    input  logic       no_pal,
    output logic       supported,
    output logic [2:0] bpp_log,
    output pix_fmt_e   fmt,
    output logic [9:0] offset
);

    // Depth and format from the code.
    always_comb begin
        supported = 1'b1;
        bpp_log   = 3'd4;
        fmt       = tft ? FMT_C16 : FMT_C12;
        case (code)
            3'd0: begin supported = 1'b0; bpp_log = 3'd0; fmt = FMT_P2; end
            3'd1: begin bpp_log = 3'd1; fmt = FMT_P2; end
            3'd2: begin bpp_log = 3'd2; fmt = FMT_P4; end
            3'd3: begin bpp_log = 3'd3; fmt = FMT_P8; end
            default: ;
        endcase
    end

    // Pixel data offset past the palette area.
    always_comb begin
        if (no_pal)            offset = 10'h000;
        else if (code >= 3'd3) offset = 10'h200;
        else                   offset = 10'h020;
    end

endmodule

// File: rtl/fhd_fit_check.sv
// Module: fhd_fit_check
// Checks the frame size against the buffer, and derives the stride and line range.
// Assumes: bpp is a power of two from 2 to 16, so every scaling is a shift.
module fhd_fit_check #(
    parameter int AW    = 32,
    parameter int DIM_W = 10,
    localparam int AREA_W = 2 * (DIM_W + 1),
    localparam int CMP_W  = ((AW > AREA_W + 2) ? AW : AREA_W + 2) + 1,
    localparam int STR_W  = DIM_W + 2
) (
    input  logic [DIM_W-1:0] w_m1,
    input  logic [DIM_W-1:0] h_m1,
    input  logic [2:0]       bpp_log,
    input  logic [9:0]       offset,
    input  logic [AW-1:0]    buf_size,
    input  logic             sub_on,
    input  logic             sub_first_mode,
    input  logic [DIM_W-1:0] sub_value,
    output logic             fits,
    output logic [STR_W-1:0] stride,
    output logic [DIM_W-1:0] first_line,
    output logic [DIM_W:0]   line_count
);

    logic [DIM_W:0]    width;
    logic [DIM_W:0]    height;
    logic [AREA_W-1:0] area;
    logic [CMP_W-1:0]  area_x;
    logic [CMP_W-1:0]  pix_bytes;
    logic [CMP_W-1:0]  need;
    logic [CMP_W-1:0]  limit;

    assign width  = {1'b0, w_m1} + 1'b1;
    assign height = {1'b0, h_m1} + 1'b1;
    assign area   = AREA_W'(width) * AREA_W'(height);
    assign area_x = CMP_W'(area);

    // Bytes of pixel data: area*bpp/8 by shifting.
    always_comb begin
        case (bpp_log)
            3'd1:    pix_bytes = area_x >> 2;
            3'd2:    pix_bytes = area_x >> 1;
            3'd3:    pix_bytes = area_x;
            3'd4:    pix_bytes = area_x << 1;
            default: pix_bytes = '0;
        endcase
    end

    assign need  = pix_bytes + CMP_W'(offset);
    assign limit = CMP_W'(buf_size) + CMP_W'(2);
    assign fits  = (need <= limit);

    // Line stride: width*bpp/8 by shifting.
    always_comb begin
        case (bpp_log)
            3'd1:    stride = STR_W'(width) >> 2;
            3'd2:    stride = STR_W'(width) >> 1;
            3'd3:    stride = STR_W'(width);
            3'd4:    stride = STR_W'(width) << 1;
            default: stride = '0;
        endcase
    end

    // Sub-panel picks the first line or the line count.
    always_comb begin
        first_line = '0;
        line_count = height;
        if (sub_on) begin
            if (sub_first_mode) first_line = sub_value;
            else                line_count = {1'b0, sub_value};
        end
    end

endmodule

// File: rtl/frame_hdr_decoder.sv
// Module: frame_hdr_decoder (top)
// Per-frame sequencer: decides whether to fetch, loads the palette, evaluates the header,
// and emits one result pulse with the registered frame parameters.
// Assumes: configuration inputs are stable from frame_start until the result pulse.
module frame_hdr_decoder
    import fhd_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DIM_W  = 10,
    parameter int PAL_DW = 16,
    parameter int PAL_N  = 256,
    localparam int IDX_W = $clog2(PAL_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              ctl_enable,
    input  logic [1:0]        pal_mode,
    input  logic              tft_sel,
    input  logic [DIM_W-1:0]  pix_w_m1,
    input  logic [DIM_W-1:0]  lines_m1,
    input  logic              sub_on,
    input  logic              sub_first_mode,
    input  logic [DIM_W-1:0]  sub_value,
    input  logic [AW-1:0]     buf_base,
    input  logic [AW-1:0]     buf_size,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_ack,
    input  logic [PAL_DW-1:0] mem_rdata,
    input  logic [IDX_W-1:0]  pal_idx,
    output logic [PAL_DW-1:0] pal_entry,
    output logic              palette_done,
    output logic              frame_go,
    output logic              frame_skip,
    output logic              sync_err,
    output logic [4:0]        bpp_out,
    output logic [2:0]        fmt_out,
    output logic [AW-1:0]     data_addr,
    output logic [DIM_W+1:0]  line_stride,
    output logic [DIM_W-1:0]  first_line,
    output logic [DIM_W:0]    line_count
);

    seq_state_e       state;
    logic             no_pal_q;
    logic             accept;
    logic             ld_start;
    logic             ld_done;
    logic [2:0]       hdr_code;
    logic             supported;
    logic [2:0]       bpp_log;
    pix_fmt_e         fmt;
    logic [9:0]       offset;
    logic             fits;
    logic [DIM_W+1:0] stride_c;
    logic [DIM_W-1:0] first_c;
    logic [DIM_W:0]   count_c;

    assign accept   = (state == ST_IDLE) && frame_start && ctl_enable;
    assign ld_start = accept && (pal_mode != MODE_NOFETCH) && (pal_mode != MODE_NOPAL);
    assign palette_done = ld_done;

    fhd_pal_loader #(
        .AW(AW), .PAL_DW(PAL_DW), .PAL_N(PAL_N)
    ) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ld_start),
        .base     (buf_base),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .rd_idx   (pal_idx),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .hdr_code (hdr_code),
        .done     (ld_done),
        .rd_data  (pal_entry)
    );

    fhd_hdr_decode u_decode (
        .code     (hdr_code),
        .tft      (tft_sel),
        .no_pal   (no_pal_q),
        .supported(supported),
        .bpp_log  (bpp_log),
        .fmt      (fmt),
        .offset   (offset)
    );

    fhd_fit_check #(
        .AW(AW), .DIM_W(DIM_W)
    ) u_fit (
        .w_m1          (pix_w_m1),
        .h_m1          (lines_m1),
        .bpp_log       (bpp_log),
        .offset        (offset),
        .buf_size      (buf_size),
        .sub_on        (sub_on),
        .sub_first_mode(sub_first_mode),
        .sub_value     (sub_value),
        .fits          (fits),
        .stride        (stride_c),
        .first_line    (first_c),
        .line_count    (count_c)
    );

    // Frame sequencer and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            no_pal_q    <= 1'b0;
            frame_go    <= 1'b0;
            frame_skip  <= 1'b0;
            sync_err    <= 1'b0;
            bpp_out     <= '0;
            fmt_out     <= '0;
            data_addr   <= '0;
            line_stride <= '0;
            first_line  <= '0;
            line_count  <= '0;
        end else begin
            frame_go   <= 1'b0;
            frame_skip <= 1'b0;
            sync_err   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (pal_mode == MODE_NOFETCH) begin
                            frame_skip <= 1'b1;
                        end else if (pal_mode == MODE_NOPAL) begin
                            no_pal_q <= 1'b1;
                            state    <= ST_EVAL;
                        end else begin
                            no_pal_q <= 1'b0;
                            state    <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    if (ld_done) state <= ST_EVAL;
                end
                ST_EVAL: begin
                    state <= ST_IDLE;
                    if (!supported) begin
                        frame_skip <= 1'b1;
                    end else if (!fits) begin
                        sync_err <= 1'b1;
                    end else begin
                        frame_go    <= 1'b1;
                        bpp_out     <= 5'd1 << bpp_log;
                        fmt_out     <= fmt;
                        data_addr   <= buf_base + AW'(offset);
                        line_stride <= stride_c;
                        first_line  <= first_c;
                        line_count  <= count_c;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_one_result_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_go, frame_skip, sync_err}));

    p_no_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pal_mode == MODE_NOFETCH) |=> !mem_req);

    p_no_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pal_mode == MODE_NOPAL) |=> !mem_req);

    p_err_unfit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !$past(fits));

    p_go_fits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |-> ($past(fits) && $past(supported)));

    p_params_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_go |-> ($stable(data_addr) && $stable(line_count)));

endmodule

// File: tb/test_frame_hdr_decoder.sv
`timescale 1ns/1ps
module test_frame_hdr_decoder;

    localparam int AW = 32;
    localparam int DIM_W = 10;
    localparam logic [31:0] BASE = 32'h1000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic ctl_enable = 1'b0;
    logic [1:0] pal_mode = 2'd0;
    logic tft_sel = 1'b0;
    logic [DIM_W-1:0] pix_w_m1 = '0;
    logic [DIM_W-1:0] lines_m1 = '0;
    logic sub_on = 1'b0;
    logic sub_first_mode = 1'b0;
    logic [DIM_W-1:0] sub_value = '0;
    logic [AW-1:0] buf_base = BASE;
    logic [AW-1:0] buf_size = 32'h2000;
    logic mem_req;
    logic [AW-1:0] mem_addr;
    logic mem_ack;
    logic [15:0] mem_rdata;
    logic [7:0] pal_idx = '0;
    logic [15:0] pal_entry;
    logic palette_done, frame_go, frame_skip, sync_err;
    logic [4:0] bpp_out;
    logic [2:0] fmt_out;
    logic [AW-1:0] data_addr;
    logic [DIM_W+1:0] line_stride;
    logic [DIM_W-1:0] first_line;
    logic [DIM_W:0] line_count;

    logic [15:0] hdr_word = 16'h0000;
    int reads = 0;
    int checks = 0;
    int failures = 0;
    int got_go, got_skip, got_err, got_pd;

    always #4 clk = ~clk;

    frame_hdr_decoder i_frame_hdr_decoder (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ctl_enable(ctl_enable),
        .pal_mode(pal_mode), .tft_sel(tft_sel), .pix_w_m1(pix_w_m1), .lines_m1(lines_m1),
        .sub_on(sub_on), .sub_first_mode(sub_first_mode), .sub_value(sub_value),
        .buf_base(buf_base), .buf_size(buf_size), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pal_idx(pal_idx), .pal_entry(pal_entry),
        .palette_done(palette_done), .frame_go(frame_go), .frame_skip(frame_skip),
        .sync_err(sync_err), .bpp_out(bpp_out), .fmt_out(fmt_out), .data_addr(data_addr),
        .line_stride(line_stride), .first_line(first_line), .line_count(line_count)
    );

    function automatic logic [15:0] word_at(input logic [31:0] a);
        return (a == BASE) ? hdr_word : (a[15:0] ^ 16'h5A5A);
    endfunction

    // Memory model: acknowledges every other cycle and counts reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            mem_rdata <= word_at(mem_addr);
            if (mem_ack) reads <= reads + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame();
        got_go = 0; got_skip = 0; got_err = 0; got_pd = 0;
        @(negedge clk);
        frame_start = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            frame_start = 1'b0;
            if (palette_done) got_pd++;
            if (frame_go || frame_skip || sync_err) begin
                got_go = int'(frame_go); got_skip = int'(frame_skip); got_err = int'(sync_err);
                break;
            end
        end
        repeat (3) begin
            @(negedge clk);
            if (frame_go || frame_skip || sync_err) begin
                got_go += 10;
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 pulses", {29'd0, frame_go, frame_skip, sync_err}, 0);
        chk("R1 data_addr", data_addr, 0);
        chk("R1 bpp", 32'(bpp_out), 0);
    endtask

    task automatic t_disabled();
        int r0 = reads;
        ctl_enable = 1'b0;
        run_frame();
        chk("R2 no pulse while disabled", 32'(got_go + got_skip + got_err), 0);
        chk("R2 no read while disabled", 32'(reads - r0), 0);
        ctl_enable = 1'b1;
    endtask

    task automatic t_load_8bpp();
        int r0 = reads;
        pal_mode = 2'd0; hdr_word = 16'h3000; pix_w_m1 = 10'd63; lines_m1 = 10'd15;
        buf_size = 32'h2000; tft_sel = 1'b0;
        run_frame();
        chk("R3 read count", 32'(reads - r0), 256);
        chk("R3 palette_done once", 32'(got_pd), 1);
        chk("R13 one go", 32'(got_go), 1);
        chk("R4 bpp 8", 32'(bpp_out), 8);
        chk("R5 fmt 8bpp", 32'(fmt_out), 2);
        chk("R6 offset 0x200", data_addr, BASE + 32'h200);
        chk("R12 stride", 32'(line_stride), 64);
        chk("R11 no subpanel count", 32'(line_count), 16);
        chk("R11 no subpanel first", 32'(first_line), 0);
        pal_idx = 8'd0; #1;
        chk("R3 entry0", 32'(pal_entry), 32'h3000);
        pal_idx = 8'd200; #1;
        chk("R3 entry200", 32'(pal_entry), 32'(word_at(BASE + 32'd400)));
    endtask

    task automatic t_2bpp();
        pal_mode = 2'd3; hdr_word = 16'h9000; pix_w_m1 = 10'd99; lines_m1 = 10'd9;
        run_frame();
        chk("R13 go 2bpp", 32'(got_go), 1);
        chk("R4 bpp 2", 32'(bpp_out), 2);
        chk("R5 fmt 2bpp", 32'(fmt_out), 0);
        chk("R6 offset 0x20", data_addr, BASE + 32'h20);
        chk("R12 stride 2bpp", 32'(line_stride), 25);
        hdr_word = 16'h2000;
        run_frame();
        chk("R4 bpp 4", 32'(bpp_out), 4);
        chk("R5 fmt 4bpp", 32'(fmt_out), 1);
        chk("R12 stride 4bpp", 32'(line_stride), 50);
    endtask

    task automatic t_16bpp();
        pal_mode = 2'd0; hdr_word = 16'h5000; pix_w_m1 = 10'd31; lines_m1 = 10'd7; tft_sel = 1'b0;
        run_frame();
        chk("R4 bpp 16", 32'(bpp_out), 16);
        chk("R5 fmt 12-bit", 32'(fmt_out), 3);
        chk("R12 stride 16bpp", 32'(line_stride), 64);
        hdr_word = 16'h7FFF; tft_sel = 1'b1;
        run_frame();
        chk("R5 fmt 16-bit", 32'(fmt_out), 4);
        chk("R6 offset code7", data_addr, BASE + 32'h200);
        tft_sel = 1'b0;
    endtask

    task automatic t_code0();
        logic [31:0] prev;
        prev = data_addr;
        hdr_word = 16'h8FFF; pal_mode = 2'd0;
        run_frame();
        chk("R9 skip", 32'(got_skip), 1);
        chk("R9 no go", 32'(got_go), 0);
        chk("R13 params held", data_addr, prev);
    endtask

    task automatic t_boundary();
        pal_mode = 2'd0; hdr_word = 16'h3000; pix_w_m1 = 10'd63; lines_m1 = 10'd15;
        buf_size = 32'd1534;
        run_frame();
        chk("R10 exact fit accepted", 32'(got_go), 1);
        buf_size = 32'd1533;
        run_frame();
        chk("R10 one byte over gives sync_err", 32'(got_err), 1);
        chk("R10 no go when over", 32'(got_go), 0);
        buf_size = 32'h2000;
    endtask

    task automatic t_mode1();
        int r0 = reads;
        pal_mode = 2'd1;
        run_frame();
        chk("R7 skip", 32'(got_skip), 1);
        chk("R7 no reads", 32'(reads - r0), 0);
    endtask

    task automatic t_mode2();
        int r0;
        pal_mode = 2'd0; hdr_word = 16'h3000; pix_w_m1 = 10'd63; lines_m1 = 10'd15;
        run_frame();
        r0 = reads;
        hdr_word = 16'h1000;
        pal_mode = 2'd2;
        run_frame();
        chk("R8 no reads", 32'(reads - r0), 0);
        chk("R8 no palette_done", 32'(got_pd), 0);
        chk("R8 go", 32'(got_go), 1);
        chk("R8 kept depth 8", 32'(bpp_out), 8);
        chk("R6 mode2 offset 0", data_addr, BASE);
    endtask

    task automatic t_mode2_after_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pal_mode = 2'd2;
        run_frame();
        chk("R8 reset code gives skip", 32'(got_skip), 1);
    endtask

    task automatic t_subpanel();
        pal_mode = 2'd0; hdr_word = 16'h3000; pix_w_m1 = 10'd63; lines_m1 = 10'd15;
        sub_on = 1'b1; sub_first_mode = 1'b1; sub_value = 10'd5;
        run_frame();
        chk("R11 first line", 32'(first_line), 5);
        chk("R11 count kept", 32'(line_count), 16);
        sub_first_mode = 1'b0; sub_value = 10'd7;
        run_frame();
        chk("R11 count set", 32'(line_count), 7);
        chk("R11 first zero", 32'(first_line), 0);
        sub_on = 1'b0; sub_first_mode = 1'b1; sub_value = 10'd9;
        run_frame();
        chk("R11 off first", 32'(first_line), 0);
        chk("R11 off count", 32'(line_count), 16);
        sub_first_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_disabled();
        t_load_8bpp();
        t_2bpp();
        t_16bpp();
        t_code0();
        t_boundary();
        t_mode1();
        t_mode2();
        t_subpanel();
        t_mode2_after_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule